// File: doc/BRIEF.md
# Sixteen-Bit Counter/Timer with Selectable Clock Sources

This block is a 16-bit down-counter that runs in one of two modes. The count is loaded from a preload value that software writes one byte at a time. In counter mode it is an event counter. After a start command it counts source events down from the preload. It flags readiness when it reaches zero, then wraps and keeps going until a stop command halts it. In timer mode it runs all the time. It reloads from the preload each time it reaches zero and toggles a square-wave output, which can serve as a port output or as a baud clock for a serial channel.

A single 3-bit select chooses both the mode and the count source. The sources are an external pin, the 1x clocks of two transmitters, and the block's own clock, and some sources pass through a divide-by-16 prescaler. The start and stop commands arrive as read strobes, because the external bus decoder turns reads of two addresses into those commands. The live count is read back as an upper byte followed by a lower byte. The lower byte is captured when the upper byte is read, so the two reads always describe the same count.

Top module: `ctmr_top`

## Requirements
- R1: While `rst` is high and after it falls, the count, the preload and the mode select are 0, `cnt_ready` is 0, `tmr_out` is 0 and the counter is stopped.
- R2: Select codes 3'b000, 3'b001 and 3'b010 are counter mode, fed undivided from `ext_in`, `txa_clk` and `txb_clk` respectively, and rising edges on unselected inputs leave the count unchanged.
- R3: Select codes 3'b100 to 3'b111 are timer mode, fed from `ext_in`, `ext_in`/16, the clock, and the clock/16 respectively, and rising edges on unselected inputs have no effect.
- R4: With a /16 source (codes 3'b011 = clock/16 counter, 3'b101, 3'b111), the count changes once per 16 source events. The prescaler is cleared by a start or a select write, so with clock/16 the first change comes on the 16th clock edge after the start edge.
- R5: In counter mode, after a start the count falls by one per source event. `cnt_ready` is set by the event that takes the count from 1 to 0. The next event wraps the count to 16'hFFFF and counting continues.
- R6: A pulse on `stop_rd` clears `cnt_ready` on the next edge (the stop wins over a simultaneous set). In counter mode it also halts the count, and no later source event changes it until the next start.
- R7: In timer mode, an event that finds the count at 1 (or 0) reloads the preload, toggles `tmr_out` and sets `cnt_ready`; any other event decrements. With preload N ≥ 1 the output therefore toggles every N events.
- R8: In timer mode `stop_rd` does not halt counting; it only clears `cnt_ready`.
- R9: A pulse on `start_rd` loads the count from the preload on the next edge, drives `tmr_out` to 0 and starts a counter-mode run.
- R10: `pre_hi_wr` writes `wdata` into preload bits 15:8 and `pre_lo_wr` into bits 7:0. While `cnt_hi_rd` is high, `rdata` shows count bits 15:8 and captures bits 7:0. While `cnt_lo_rd` is high, `rdata` shows the captured byte. With neither strobe high, `rdata` is 0.
- R11: `ext_in`, `txa_clk` and `txb_clk` are asynchronous. Each passes through a two-stage synchronizer, and only its rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the master count source |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode/source select |
| mode_sel | input | 3 | Mode/source select code |
| pre_hi_wr | input | 1 | Write `wdata` to preload upper byte |
| pre_lo_wr | input | 1 | Write `wdata` to preload lower byte |
| wdata | input | 8 | Write data byte |
| start_rd | input | 1 | Start command (read side effect) |
| stop_rd | input | 1 | Stop command (read side effect) |
| cnt_hi_rd | input | 1 | Read strobe for count upper byte |
| cnt_lo_rd | input | 1 | Read strobe for captured count lower byte |
| rdata | output | 8 | Read data byte |
| ext_in | input | 1 | External count input pin |
| txa_clk | input | 1 | Transmitter A 1x clock |
| txb_clk | input | 1 | Transmitter B 1x clock |
| cnt_ready | output | 1 | Counter-ready flag to the interrupt logic |
| tmr_out | output | 1 | Timer square-wave output |

## Verification
The assertions check the behaviour of each single edge on every cycle. These are the reload and output toggle at a timer terminal count, the wrap from zero in counter mode, the ready flag set at zero and cleared by stop, the preload captured on start, the frozen count while stopped, and the coherence of the lower-byte read. Only the bench scenarios can show the longer-range behaviour. This covers the mapping of each select code to its source, the rejection of events on unselected inputs, the sixteen-event spacing of the prescaled sources, the exact toggle period of the timer output, and the end-to-end byte-wise preload and readback.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_TXA  = 2'd1,
        SRC_TXB  = 2'd2,
        SRC_MCLK = 2'd3
    } src_e;

    typedef struct packed {
        logic timer;
        src_e src;
        logic div16;
    } cfg_t;

    // Map the 3-bit select onto mode, source and prescale.
    function automatic cfg_t decode_sel(input logic [2:0] sel);
        cfg_t c;
        case (sel)
            3'b000:  c = '{timer: 1'b0, src: SRC_EXT,  div16: 1'b0};
            3'b001:  c = '{timer: 1'b0, src: SRC_TXA,  div16: 1'b0};
            3'b010:  c = '{timer: 1'b0, src: SRC_TXB,  div16: 1'b0};
            3'b011:  c = '{timer: 1'b0, src: SRC_MCLK, div16: 1'b1};
            3'b100:  c = '{timer: 1'b1, src: SRC_EXT,  div16: 1'b0};
            3'b101:  c = '{timer: 1'b1, src: SRC_EXT,  div16: 1'b1};
            3'b110:  c = '{timer: 1'b1, src: SRC_MCLK, div16: 1'b0};
            default: c = '{timer: 1'b1, src: SRC_MCLK, div16: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctmr_srcsel.sv
module ctmr_srcsel
    import ctmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 4
) (
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic div16,
    input  logic run_en,
    input  logic pre_clr,
    input  logic ext_in,
    input  logic txa_clk,
    input  logic txb_clk,
    output logic tick
);
    localparam int N_PINS = 3;

    logic [N_PINS-1:0] raw;
    logic [N_PINS-1:0] rise;
    logic              src_ev;
    logic [DIV_LOG2-1:0] pre_q;

    assign raw = {txb_clk, txa_clk, ext_in};

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [SYNC_STAGES-1:0] stg_q;
        logic                   last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q  <= '0;
                last_q <= 1'b0;
            end else begin
                stg_q  <= {stg_q[SYNC_STAGES-2:0], raw[i]};
                last_q <= stg_q[SYNC_STAGES-1];
            end
        end
        assign rise[i] = stg_q[SYNC_STAGES-1] & ~last_q;
    end

    always_comb begin
        case (src)
            SRC_EXT:  src_ev = rise[0];
            SRC_TXA:  src_ev = rise[1];
            SRC_TXB:  src_ev = rise[2];
            default:  src_ev = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || pre_clr) begin
            pre_q <= '0;
        end else if (run_en && src_ev && div16) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run_en & src_ev & (~div16 | (&pre_q));

endmodule

// File: rtl/ctmr_count.sv
module ctmr_count
    import ctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             is_timer,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             ready,
    output logic             tout
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_one;
    logic at_zero;
    logic hit;

    assign at_one  = (count == ONE);
    assign at_zero = (count == '0);
    // terminal event: counter reaches zero, or timer needs a reload
    assign hit     = tick & (at_one | (is_timer & at_zero));

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
            tout    <= 1'b0;
        end else begin
            if (stop && !is_timer) begin
                running <= 1'b0;
            end
            if (start) begin
                count   <= preload;
                running <= 1'b1;
                tout    <= 1'b0;
            end else if (tick) begin
                if (is_timer && hit) begin
                    count <= preload;
                    tout  <= ~tout;
                end else begin
                    count <= count - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
        end else if (stop) begin
            ready <= 1'b0;
        end else if (hit && !start) begin
            ready <= 1'b1;
        end
    end

endmodule

// File: rtl/ctmr_readback.sv
module ctmr_readback
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic              hi_rd,
    input  logic              lo_rd,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (hi_rd) begin
            snap_q <= count[BYTE_W-1:0];
        end
    end

    always_comb begin
        if (hi_rd) begin
            rdata = count[CNT_W-1:BYTE_W];
        end else if (lo_rd) begin
            rdata = snap_q;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [2:0]        mode_sel,
    input  logic              pre_hi_wr,
    input  logic              pre_lo_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              start_rd,
    input  logic              stop_rd,
    input  logic              cnt_hi_rd,
    input  logic              cnt_lo_rd,
    output logic [BYTE_W-1:0] rdata,
    input  logic              ext_in,
    input  logic              txa_clk,
    input  logic              txb_clk,
    output logic              cnt_ready,
    output logic              tmr_out
);
    logic [2:0]       sel_q;
    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg;
    logic             is_timer;
    logic             running;
    logic             run_en;
    logic             tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            preload_q <= '0;
        end else begin
            if (mode_wr)   sel_q <= mode_sel;
            if (pre_hi_wr) preload_q[CNT_W-1:BYTE_W] <= wdata;
            if (pre_lo_wr) preload_q[BYTE_W-1:0]     <= wdata;
        end
    end

    assign cfg      = decode_sel(sel_q);
    assign is_timer = cfg.timer;
    assign run_en   = running | is_timer;

    ctmr_srcsel #(
        .SYNC_STAGES(SYNC_STAGES),
        .DIV_LOG2   (DIV_LOG2)
    ) u_src (
        .clk    (clk),
        .rst    (rst),
        .src    (cfg.src),
        .div16  (cfg.div16),
        .run_en (run_en),
        .pre_clr(start_rd | mode_wr),
        .ext_in (ext_in),
        .txa_clk(txa_clk),
        .txb_clk(txb_clk),
        .tick   (tick)
    );

    ctmr_count u_cnt (
        .clk     (clk),
        .rst     (rst),
        .is_timer(is_timer),
        .tick    (tick),
        .start   (start_rd),
        .stop    (stop_rd),
        .preload (preload_q),
        .count   (cnt_q),
        .running (running),
        .ready   (cnt_ready),
        .tout    (tmr_out)
    );

    ctmr_readback u_rb (
        .clk  (clk),
        .rst  (rst),
        .count(cnt_q),
        .hi_rd(cnt_hi_rd),
        .lo_rd(cnt_lo_rd),
        .rdata(rdata)
    );

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk
    import ctmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_rd,
    input logic              stop_rd,
    input logic              cnt_hi_rd,
    input logic              cnt_lo_rd,
    input logic [BYTE_W-1:0] rdata,
    input logic              cnt_ready,
    input logic              tmr_out,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  preload,
    input logic              is_timer,
    input logic              running,
    input logic              tick
);
    p_start_load_r9: assert property (@(posedge clk) disable iff (rst)
        start_rd |=> (count == $past(preload)) && !tmr_out);

    p_stop_clears_ready_r6: assert property (@(posedge clk) disable iff (rst)
        stop_rd |=> !cnt_ready);

    p_halt_when_stopped_r6: assert property (@(posedge clk) disable iff (rst)
        (!is_timer && !running && !start_rd) |=> $stable(count));

    p_out_only_timer_r7: assert property (@(posedge clk) disable iff (rst)
        (!is_timer && !start_rd) |=> $stable(tmr_out));

    p_timer_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && is_timer && (count <= CNT_W'(1)) && !start_rd)
        |=> (count == $past(preload)) && (tmr_out != $past(tmr_out)));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !is_timer && (count == '0) && !start_rd) |=> (count == '1));

    p_ready_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !is_timer && (count == CNT_W'(1)) && !start_rd && !stop_rd)
        |=> cnt_ready);

    p_coherent_lo_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_hi_rd |=> (!cnt_lo_rd || (rdata == $past(count[BYTE_W-1:0]))));

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        (!cnt_hi_rd && !cnt_lo_rd) |-> (rdata == '0));

endmodule

bind ctmr_top ctmr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_rd (start_rd),
    .stop_rd  (stop_rd),
    .cnt_hi_rd(cnt_hi_rd),
    .cnt_lo_rd(cnt_lo_rd),
    .rdata    (rdata),
    .cnt_ready(cnt_ready),
    .tmr_out  (tmr_out),
    .count    (cnt_q),
    .preload  (preload_q),
    .is_timer (is_timer),
    .running  (running),
    .tick     (tick)
);

// File: tb/ctmr_top_tb_top.sv
module ctmr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_sel = '0;
    logic       pre_hi_wr = 1'b0;
    logic       pre_lo_wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       start_rd = 1'b0;
    logic       stop_rd = 1'b0;
    logic       cnt_hi_rd = 1'b0;
    logic       cnt_lo_rd = 1'b0;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       txa_clk = 1'b0;
    logic       txb_clk = 1'b0;
    logic       cnt_ready;
    logic       tmr_out;

    logic probe_out = 1'b0;
    logic probe_rdy = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    ctmr_top dut_i (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .pre_hi_wr(pre_hi_wr), .pre_lo_wr(pre_lo_wr), .wdata(wdata),
        .start_rd(start_rd), .stop_rd(stop_rd),
        .cnt_hi_rd(cnt_hi_rd), .cnt_lo_rd(cnt_lo_rd), .rdata(rdata),
        .ext_in(ext_in), .txa_clk(txa_clk), .txb_clk(txb_clk),
        .cnt_ready(cnt_ready), .tmr_out(tmr_out)
    );

    // monitor: pops one expected item per observation window
    always @(negedge clk) begin
        if (!rst && (cnt_hi_rd || cnt_lo_rd || probe_out || probe_rdy)) begin
            logic [7:0] act;
            item_t      it;
            if (probe_out)      act = {7'd0, tmr_out};
            else if (probe_rdy) act = {7'd0, cnt_ready};
            else                act = rdata;
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual %h expected none", act);
            end else begin
                it = sb_q.pop_front();
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_mode(input logic [2:0] v);
        mode_sel = v; mode_wr = 1'b1; step(); mode_wr = 1'b0;
    endtask

    task automatic wr_pre(input logic [15:0] v);
        wdata = v[15:8]; pre_hi_wr = 1'b1; step(); pre_hi_wr = 1'b0;
        wdata = v[7:0];  pre_lo_wr = 1'b1; step(); pre_lo_wr = 1'b0;
    endtask

    task automatic do_start();
        start_rd = 1'b1; step(); start_rd = 1'b0;
    endtask

    task automatic do_stop();
        stop_rd = 1'b1; step(); stop_rd = 1'b0;
    endtask

    task automatic readcnt(input logic [15:0] exp, input string req);
        sb_q.push_back('{exp: exp[15:8], req: {req, " count hi"}});
        cnt_hi_rd = 1'b1; step(); cnt_hi_rd = 1'b0;
        sb_q.push_back('{exp: exp[7:0], req: {req, " count lo"}});
        cnt_lo_rd = 1'b1; step(); cnt_lo_rd = 1'b0;
    endtask

    task automatic chk_out(input logic e, input string req);
        sb_q.push_back('{exp: {7'd0, e}, req: {req, " tmr_out"}});
        probe_out = 1'b1; step(); probe_out = 1'b0;
    endtask

    task automatic chk_rdy(input logic e, input string req);
        sb_q.push_back('{exp: {7'd0, e}, req: {req, " cnt_ready"}});
        probe_rdy = 1'b1; step(); probe_rdy = 1'b0;
    endtask

    // pin: 0 ext, 1 txa, 2 txb
    task automatic pulse(input int pin, input int n);
        for (int k = 0; k < n; k++) begin
            case (pin)
                0: ext_in = 1'b1;
                1: txa_clk = 1'b1;
                default: txb_clk = 1'b1;
            endcase
            idle(3);
            ext_in = 1'b0; txa_clk = 1'b0; txb_clk = 1'b0;
            idle(3);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(4);
        rst = 1'b0;
        step();

        // R1: reset state
        readcnt(16'h0000, "R1");
        chk_rdy(1'b0, "R1");
        chk_out(1'b0, "R1");

        // R11 / R2: counter mode, external pin, synchronised rising edges
        wr_pre(16'h0105);
        do_start();
        readcnt(16'h0105, "R9");
        pulse(0, 5);
        readcnt(16'h0100, "R11");
        chk_rdy(1'b0, "R5");

        // R2: unselected transmitter clocks ignored
        pulse(1, 3);
        pulse(2, 2);
        readcnt(16'h0100, "R2");

        // R6: stop halts counter mode
        do_stop();
        pulse(0, 2);
        readcnt(16'h0100, "R6");
        do_start();
        readcnt(16'h0105, "R9");

        // R5: transmitter A source, reach zero, wrap
        wr_mode(3'b001);
        wr_pre(16'h0003);
        do_start();
        pulse(1, 3);
        readcnt(16'h0000, "R5");
        chk_rdy(1'b1, "R5");
        pulse(1, 1);
        readcnt(16'hFFFF, "R5");
        chk_rdy(1'b1, "R5");
        do_stop();
        chk_rdy(1'b0, "R6");
        pulse(1, 1);
        readcnt(16'hFFFF, "R6");

        // R2: transmitter B source, ext ignored
        wr_mode(3'b010);
        wr_pre(16'h0002);
        do_start();
        pulse(2, 2);
        chk_rdy(1'b1, "R2");
        pulse(0, 1);
        readcnt(16'h0000, "R2");
        do_stop();

        // R4: counter mode clock/16, preload 3; ticks at edges 16,32,48
        wr_mode(3'b011);
        wr_pre(16'h0003);
        do_start();
        idle(20);
        readcnt(16'h0002, "R4");
        idle(25);
        readcnt(16'h0001, "R4");
        chk_rdy(1'b1, "R4");
        do_stop();

        // R7 / R8: timer on clock, preload 10
        wr_mode(3'b110);
        wr_pre(16'd10);
        do_start();
        idle(12);
        chk_out(1'b1, "R7");
        do_stop();
        chk_rdy(1'b0, "R8");
        idle(6);
        chk_out(1'b0, "R7");
        readcnt(16'd8, "R8");

        // R7 / R9: preload 1 toggles every clock, start forces low
        wr_pre(16'd1);
        do_start();
        chk_out(1'b0, "R9");
        chk_out(1'b1, "R7");
        chk_out(1'b0, "R7");

        // R10: coherent byte readback across a borrow
        wr_pre(16'h0200);
        do_start();
        readcnt(16'h0200, "R10");

        // R4 / R3: timer clock/16, preload 2: toggle at edge 32
        wr_mode(3'b111);
        wr_pre(16'd2);
        do_start();
        idle(31);
        chk_out(1'b0, "R4");
        chk_out(1'b1, "R4");

        // R3: timer on external pin, txa ignored
        wr_mode(3'b100);
        wr_pre(16'd2);
        do_start();
        pulse(0, 2);
        chk_out(1'b1, "R3");
        pulse(0, 2);
        chk_out(1'b0, "R3");
        pulse(1, 2);
        chk_out(1'b0, "R3");

        // R3 / R4: timer on external pin /16, preload 1
        wr_mode(3'b101);
        wr_pre(16'd1);
        do_start();
        pulse(0, 15);
        chk_out(1'b0, "R4");
        pulse(0, 1);
        chk_out(1'b1, "R4");

        idle(2);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule